// File: doc/BRIEF.md
# Multiphase Twisted-Ring Clock Divider

This block divides its input clock by an even ratio of twice its stage count. A chain of single-bit stages shifts one place on every rising edge of the input clock. The first stage loads the inverse of the last stage, so a run of ones enters the ring and then a run of zeros follows it. Each stage output is a square wave at 1/(2·STAGES) of the input frequency. Each stage lags the one before it by exactly one input period, so the phase vector gives STAGES copies of the divided clock with equal spacing. The default build has three stages and divides by six.

A guard watches the ring for any pattern that is not on the legal cycle. A legal pattern has at most one boundary between adjacent stages that hold different values. When the guard finds an illegal pattern, the first stage loads zero in place of the inverted feedback. This drains the bad pattern out of the ring within STAGES edges. One stage, picked by a build parameter, also drives a separate divided-clock output straight from its flop.

Top module: `jdiv_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge of clk_in) sets every bit of phase_o to 0 at that edge. The all-zero pattern is a legal ring state.
- R2: At each rising edge with rst low, phase_o[j] takes the value phase_o[j-1] held before the edge, for every j from 1 to STAGES-1.
- R3: At each rising edge with rst low, when the ring holds a legal pattern, phase_o[0] takes the inverse of phase_o[STAGES-1].
- R4: With three stages and starting from reset, the pattern written as phase_o[0] phase_o[1] phase_o[2] steps through 000, 100, 110, 111, 011, 001 and then repeats.
- R5: Each phase output repeats with a period of 2·STAGES input cycles. In every period it is high for exactly STAGES cycles.
- R6: Stage j lags stage 0 by exactly j input cycles. After reset, stage j first goes high on edge j+1.
- R7: A pattern with more than one boundary between adjacent differing stages is illegal. From such a pattern, phase_o[0] loads 0 at the next edge while the other stages still shift. The ring is back on the legal cycle no later than STAGES edges after the pattern appears.
- R8: div_clk_o always equals phase_o[TAP], where TAP is a build parameter (default 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; the ring advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every stage |
| phase_o | output | STAGES | Stage outputs, bit 0 is the first stage; each is a divided clock one input period behind the bit below it |
| div_clk_o | output | 1 | Divided clock taken from stage TAP |

## Verification
The hardest case to reach is recovery from an illegal ring pattern. Reset and normal running only ever produce legal states, so the ports alone can never put the ring into one. To get there, the bench holds reset for one edge and then briefly forces the ring register to each of the 2^STAGES patterns. It releases the force and drops reset before the next edge. It then follows every later edge against a model, so each legal and illegal starting pattern is covered, including the one that needs the longest drain.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;

    localparam int unsigned JDIV_MAX_STAGES = 32;

    typedef enum logic {
        RING_RUN  = 1'b0,
        RING_MEND = 1'b1
    } ring_mode_e;

    // Number of places where adjacent stages differ, over the low n bits.
    function automatic int unsigned ring_edges(input logic [JDIV_MAX_STAGES-1:0] s,
                                               input int unsigned n);
        int unsigned c;
        c = 0;
        for (int unsigned j = 1; j < JDIV_MAX_STAGES; j++) begin
            if (j < n && (s[j] ^ s[j-1])) c++;
        end
        return c;
    endfunction

    // A twisted-ring pattern is on the legal cycle when it has at most one boundary.
    function automatic logic ring_is_legal(input logic [JDIV_MAX_STAGES-1:0] s,
                                           input int unsigned n);
        return ring_edges(s, n) <= 1;
    endfunction

endpackage

// File: rtl/jdiv_guard.sv
module jdiv_guard
    import jdiv_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic [STAGES-1:0] ring_i,
    output ring_mode_e        mode_o
);

    logic [JDIV_MAX_STAGES-1:0] pad;

    always_comb begin
        pad = '0;
        pad[STAGES-1:0] = ring_i;
        mode_o = ring_is_legal(pad, STAGES) ? RING_RUN : RING_MEND;
    end

endmodule

// File: rtl/jdiv_ring.sv
module jdiv_ring
    import jdiv_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic              clk_in,
    input  logic              rst,
    input  ring_mode_e        mode_i,
    output logic [STAGES-1:0] ring_o
);

    logic [STAGES-1:0] state_q;
    logic              feed;

    // Inverted tail in normal running; a zero is injected while the pattern is illegal.
    always_comb begin
        feed = (mode_i == RING_MEND) ? 1'b0 : ~state_q[STAGES-1];
    end

    always_ff @(posedge clk_in) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= {state_q[STAGES-2:0], feed};
        end
    end

    assign ring_o = state_q;

endmodule

// File: rtl/jdiv_top.sv
module jdiv_top
    import jdiv_pkg::*;
#(
    parameter int unsigned STAGES = 3,
    parameter int unsigned TAP    = 0
) (
    input  logic              clk_in,
    input  logic              rst,
    output logic [STAGES-1:0] phase_o,
    output logic              div_clk_o
);

    ring_mode_e        mode;
    logic [STAGES-1:0] ring;

    jdiv_guard #(.STAGES(STAGES)) u_guard (
        .ring_i (ring),
        .mode_o (mode)
    );

    jdiv_ring #(.STAGES(STAGES)) u_ring (
        .clk_in (clk_in),
        .rst    (rst),
        .mode_i (mode),
        .ring_o (ring)
    );

    assign phase_o   = ring;
    assign div_clk_o = ring[TAP];

endmodule

// File: rtl/jdiv_checker.sv
module jdiv_checker
    import jdiv_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input logic              clk_in,
    input logic              rst,
    input logic [STAGES-1:0] phase_i
);

    localparam int unsigned RW = $clog2(STAGES + 2);
    localparam logic [RW-1:0] RUN_LIMIT = RW'(STAGES);

    logic [JDIV_MAX_STAGES-1:0] pad;
    logic                       legal;
    logic                       past_rst_q;
    logic [RW-1:0]              run_q;

    always_comb begin
        pad = '0;
        pad[STAGES-1:0] = phase_i;
        legal = ring_is_legal(pad, STAGES);
    end

    always_ff @(posedge clk_in) begin
        past_rst_q <= rst;
        if (rst) run_q <= '0;
        else if (!legal) run_q <= run_q + RW'(1);
        else run_q <= '0;
        if (past_rst_q && rst) begin
            a_r1_reset_clears: assert (phase_i == '0)
                else $error("R1: ring not cleared under reset");
        end
    end

    a_r2_shift: assert property (@(posedge clk_in) disable iff (rst)
        !rst |=> phase_i[STAGES-1:1] == $past(phase_i[STAGES-2:0]));

    a_r3_invert_feed: assert property (@(posedge clk_in) disable iff (rst)
        (!rst && legal) |=> phase_i[0] == ~$past(phase_i[STAGES-1]));

    a_r7_mend_zero: assert property (@(posedge clk_in) disable iff (rst)
        (!rst && !legal) |=> phase_i[0] == 1'b0);

    a_r7_bounded: assert property (@(posedge clk_in) disable iff (rst)
        run_q < RUN_LIMIT);

endmodule

bind jdiv_top jdiv_checker #(.STAGES(STAGES)) u_chk (
    .clk_in  (clk_in),
    .rst     (rst),
    .phase_i (phase_o)
);

// File: tb/test_jdiv_top.sv
module test_jdiv_top;

    localparam int K = 3;
    localparam int P = 2 * K;
    localparam int TAP = 2;
    localparam time CLK_PERIOD = 10;

    logic          clk_in = 1'b0;
    logic          rst = 1'b1;
    logic [K-1:0]  phase;
    logic          div_clk;
    logic [K-1:0]  prev;
    logic [K-1:0]  inj_pat;
    logic [K-1:0]  hist [0:4*P];
    int            checks = 0;
    int            fails = 0;
    bit            done = 0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    jdiv_top #(.STAGES(K), .TAP(TAP)) i_jdiv_top (
        .clk_in    (clk_in),
        .rst       (rst),
        .phase_o   (phase),
        .div_clk_o (div_clk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Ring contents n edges after reset release, derived from R4/R6.
    function automatic logic [K-1:0] model_state(input int n);
        logic [K-1:0] s;
        for (int j = 0; j < K; j++) begin
            int b;
            b = ((n - j) % P + P) % P;
            s[j] = (b >= 1 && b <= K);
        end
        return s;
    endfunction

    function automatic bit is_valid(input logic [K-1:0] s);
        for (int n = 0; n < P; n++) if (model_state(n) == s) return 1'b1;
        return 1'b0;
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (2) @(negedge clk_in);
        check("R1 reset clears ring", phase, 0);
        check("R8 tap under reset", div_clk, phase[TAP]);
        hist[0] = phase;
        prev = phase;
        rst = 1'b0;

        // Free running from reset: sequence, shift, feedback, period, tap
        for (int n = 1; n <= 4 * P; n++) begin
            @(negedge clk_in);
            hist[n] = phase;
            check("R4 R6 state order", phase, model_state(n));
            check("R2 shift", phase[K-1:1], prev[K-2:0]);
            check("R3 inverted feedback", phase[0], {~prev[K-1]});
            check("R8 tap output", div_clk, phase[TAP]);
            if (n > P) check("R5 period", phase, hist[n-P]);
            prev = phase;
        end

        // R5: duty over one full period; R6: first rise of each stage
        for (int j = 0; j < K; j++) begin
            int hi;
            int first;
            hi = 0;
            first = -1;
            for (int n = P + 1; n <= 2 * P; n++) hi += hist[n][j];
            check("R5 duty high count", hi, K);
            for (int n = 4 * P; n >= 1; n--) if (hist[n][j]) first = n;
            check("R6 first rise edge", first, j + 1);
        end

        // R1: reset in mid-run from a nonzero state
        repeat (2) @(negedge clk_in);
        check("R1 nonzero before mid reset", {phase != 0}, 1);
        rst = 1'b1;
        @(negedge clk_in);
        check("R1 mid-run reset", phase, 0);

        // R7: every pattern injected, then followed edge by edge
        for (int p = 0; p < (1 << K); p++) begin
            logic [K-1:0] cur;
            rst = 1'b1;
            @(negedge clk_in);
            inj_pat = K'(p);
            force i_jdiv_top.u_ring.state_q = inj_pat;
            #1;
            release i_jdiv_top.u_ring.state_q;
            rst = 1'b0;
            check("R7 injected pattern", phase, inj_pat);
            cur = inj_pat;
            for (int e = 1; e <= K + 1; e++) begin
                logic [K-1:0] exp;
                @(negedge clk_in);
                exp = {cur[K-2:0], (is_valid(cur) ? ~cur[K-1] : 1'b0)};
                check("R7 recovery step", phase, exp);
                if (e == K) check("R7 legal within bound", {is_valid(phase)}, 1);
                cur = exp;
            end
        end

        finish_up();
    end

endmodule